// File: doc/BRIEF.md
# Partitioned SIMD Magnitude Comparator

This block compares two 16-bit operands as a set of independent unsigned lanes. A small partition control picks the lane size at run time. The choices are one 16-bit lane, two 8-bit lanes or four 4-bit lanes. For each lane the block produces all six relations at the same time: equal, not-equal, less, less-or-equal, greater and greater-or-equal. It is meant to sit beside a partitioned adder in a SIMD datapath, so that one compare unit serves every element width.

Each relation comes out as a 4-bit vector with one flag per 4-bit slot. A lane writes its result only into the flag of its lowest slot. The flags of its upper slots always read 0. Inside the block, each slot has a small compare cell. The cells form a chain that is cut at each enabled lane boundary and joined across each disabled one. An optional output register adds one cycle of latency.

Top module: `simd_lane_cmp`

## Requirements
- R1: With `part_cut` = 3'b000 the word is one unsigned 16-bit lane, and its six results appear in flag bit 0.
- R2: With `part_cut` = 3'b010 the word is two lanes, bits 15:8 and 7:0, and their results appear in flag bits 2 and 0 respectively.
- R3: With `part_cut` = 3'b111 the word is four 4-bit lanes, and lane k (bits 4k+3:4k) reports in flag bit k.
- R4: All comparisons are unsigned, so an operand with its lane's top bit set is greater than any operand with that bit clear and the other bits smaller.
- R5: A lane's result depends only on operand bits inside that lane; differences in other lanes leave it unchanged.
- R6: At every reporting flag bit, exactly one of lt, eq and gt is 1; ne is the inverse of eq, le equals lt or eq, and ge equals gt or eq.
- R7: Flag bits that are not the lowest slot of a lane read 0 in all six outputs.
- R8: With `OUT_REG` = 1 the outputs reflect the inputs one clock later, and a synchronous active-high `rst` clears all six outputs to 0.
- R9: With `OUT_REG` = 0 the outputs follow the inputs combinationally, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| part_cut | input | 3 | Bit i places a lane boundary between bits 4(i+1)-1 and 4(i+1) |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| rel_eq | output | 4 | Per-slot flag: lane operands equal |
| rel_ne | output | 4 | Per-slot flag: lane operands differ |
| rel_lt | output | 4 | Per-slot flag: opa less than opb |
| rel_le | output | 4 | Per-slot flag: opa less than or equal to opb |
| rel_gt | output | 4 | Per-slot flag: opa greater than opb |
| rel_ge | output | 4 | Per-slot flag: opa greater than or equal to opb |

## Verification
The bench builds the block twice with the default 4-bit slots and four slots. One copy has `OUT_REG` = 1, so the queue-based scoreboard sees the one-cycle latency, the reset clearing and the flags of the upper slots being held at 0. The other copy has `OUT_REG` = 0, which lets the same expected values be checked with no delay. Together the two builds exercise both branches of the output stage against one lane model that the bench works out from the partition value.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

    localparam int SLOT_W    = 4;
    localparam int NUM_SLOTS = 4;
    localparam int NUM_RELS  = 6;

    // Ordering of one slot or one merged run of slots.
    typedef struct packed {
        logic eq;
        logic gt;
    } ord_t;

    // Combine a more significant run (hi) with the next lower slot (lo).
    function automatic ord_t ord_merge(ord_t hi, ord_t lo);
        ord_t r;
        r.eq = hi.eq & lo.eq;
        r.gt = hi.gt | (hi.eq & lo.gt);
        return r;
    endfunction

endpackage

// File: rtl/simd_cmp_slot.sv
module simd_cmp_slot
    import simd_cmp_pkg::*;
#(
    parameter int SLOT_W = simd_cmp_pkg::SLOT_W
) (
    input  logic [SLOT_W-1:0] a,
    input  logic [SLOT_W-1:0] b,
    output ord_t              ord
);
    always_comb begin
        ord.eq = (a == b);
        ord.gt = (a > b);
    end
endmodule

// File: rtl/simd_cmp_chain.sv
module simd_cmp_chain
    import simd_cmp_pkg::*;
#(
    parameter int NUM_SLOTS = simd_cmp_pkg::NUM_SLOTS
) (
    input  ord_t [NUM_SLOTS-1:0] slot_ord,
    input  logic [NUM_SLOTS-2:0] cut,
    output ord_t [NUM_SLOTS-1:0] run_ord,
    output logic [NUM_SLOTS-1:0] lane_low
);
    // Top slot starts its own run.
    assign run_ord[NUM_SLOTS-1] = slot_ord[NUM_SLOTS-1];
    assign lane_low[0]          = 1'b1;

    genvar i;
    generate
        for (i = 0; i < NUM_SLOTS-1; i++) begin : g_link
            // Boundary i sits above slot i: cut restarts the run here.
            assign run_ord[i] = cut[i] ? slot_ord[i]
                                       : ord_merge(run_ord[i+1], slot_ord[i]);
            assign lane_low[i+1] = cut[i];
        end
    endgenerate
endmodule

// File: rtl/simd_cmp_encode.sv
module simd_cmp_encode
    import simd_cmp_pkg::*;
#(
    parameter int NUM_SLOTS = simd_cmp_pkg::NUM_SLOTS
) (
    input  ord_t [NUM_SLOTS-1:0] run_ord,
    input  logic [NUM_SLOTS-1:0] lane_low,
    output logic [NUM_SLOTS-1:0] eq,
    output logic [NUM_SLOTS-1:0] ne,
    output logic [NUM_SLOTS-1:0] lt,
    output logic [NUM_SLOTS-1:0] le,
    output logic [NUM_SLOTS-1:0] gt,
    output logic [NUM_SLOTS-1:0] ge
);
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            eq[s] = lane_low[s] &  run_ord[s].eq;
            ne[s] = lane_low[s] & ~run_ord[s].eq;
            gt[s] = lane_low[s] &  run_ord[s].gt;
            lt[s] = lane_low[s] & ~run_ord[s].eq & ~run_ord[s].gt;
            le[s] = lane_low[s] & ~run_ord[s].gt;
            ge[s] = lane_low[s] & (run_ord[s].gt | run_ord[s].eq);
        end
    end
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp
    import simd_cmp_pkg::*;
#(
    parameter int SLOT_W    = simd_cmp_pkg::SLOT_W,
    parameter int NUM_SLOTS = simd_cmp_pkg::NUM_SLOTS,
    parameter bit OUT_REG   = 1'b1,
    localparam int DATA_W   = SLOT_W * NUM_SLOTS,
    localparam int CUT_W    = NUM_SLOTS - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CUT_W-1:0]     part_cut,
    input  logic [DATA_W-1:0]    opa,
    input  logic [DATA_W-1:0]    opb,
    output logic [NUM_SLOTS-1:0] rel_eq,
    output logic [NUM_SLOTS-1:0] rel_ne,
    output logic [NUM_SLOTS-1:0] rel_lt,
    output logic [NUM_SLOTS-1:0] rel_le,
    output logic [NUM_SLOTS-1:0] rel_gt,
    output logic [NUM_SLOTS-1:0] rel_ge
);
    localparam int REL_W = NUM_RELS * NUM_SLOTS;

    ord_t [NUM_SLOTS-1:0] slot_ord;
    ord_t [NUM_SLOTS-1:0] run_ord;
    logic [NUM_SLOTS-1:0] lane_low;
    logic [NUM_SLOTS-1:0] c_eq, c_ne, c_lt, c_le, c_gt, c_ge;
    logic [REL_W-1:0]     rel_comb;
    logic [REL_W-1:0]     rel_out;

    genvar i;
    generate
        for (i = 0; i < NUM_SLOTS; i++) begin : g_slot
            simd_cmp_slot #(.SLOT_W(SLOT_W)) u_slot (
                .a   (opa[i*SLOT_W +: SLOT_W]),
                .b   (opb[i*SLOT_W +: SLOT_W]),
                .ord (slot_ord[i])
            );
        end
    endgenerate

    simd_cmp_chain #(.NUM_SLOTS(NUM_SLOTS)) u_chain (
        .slot_ord (slot_ord),
        .cut      (part_cut),
        .run_ord  (run_ord),
        .lane_low (lane_low)
    );

    simd_cmp_encode #(.NUM_SLOTS(NUM_SLOTS)) u_enc (
        .run_ord  (run_ord),
        .lane_low (lane_low),
        .eq       (c_eq),
        .ne       (c_ne),
        .lt       (c_lt),
        .le       (c_le),
        .gt       (c_gt),
        .ge       (c_ge)
    );

    assign rel_comb = {c_eq, c_ne, c_lt, c_le, c_gt, c_ge};

    generate
        if (OUT_REG) begin : g_reg
            logic [REL_W-1:0] rel_q;
            always_ff @(posedge clk) begin
                if (rst) rel_q <= '0;
                else     rel_q <= rel_comb;
            end
            assign rel_out = rel_q;
        end else begin : g_comb
            assign rel_out = rel_comb;
        end
    endgenerate

    assign {rel_eq, rel_ne, rel_lt, rel_le, rel_gt, rel_ge} = rel_out;

endmodule

// File: rtl/simd_lane_cmp_chk.sv
module simd_lane_cmp_chk #(
    parameter int NUM_SLOTS = 4,
    parameter bit OUT_REG   = 1'b1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_SLOTS-2:0] part_cut,
    input logic [NUM_SLOTS-1:0] rel_eq,
    input logic [NUM_SLOTS-1:0] rel_ne,
    input logic [NUM_SLOTS-1:0] rel_lt,
    input logic [NUM_SLOTS-1:0] rel_le,
    input logic [NUM_SLOTS-1:0] rel_gt,
    input logic [NUM_SLOTS-1:0] rel_ge,
    input logic [4*NUM_SLOTS-1:0] opa,
    input logic [4*NUM_SLOTS-1:0] opb
);
    logic                 armed;
    logic [NUM_SLOTS-1:0] low_now, low_q, low_use;
    logic                 all4_eq_now, all4_eq_q, all4_eq_use;

    assign low_now     = {part_cut, 1'b1};
    assign all4_eq_now = (part_cut == '1) && (opa == opb);

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
        low_q     <= low_now;
        all4_eq_q <= all4_eq_now;
    end

    assign low_use     = OUT_REG ? low_q : low_now;
    assign all4_eq_use = OUT_REG ? all4_eq_q : all4_eq_now;

    AST_EQ_NE_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        (rel_eq & rel_ne) == '0); // R6
    AST_LT_GT_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        (rel_lt & rel_gt) == '0); // R6
    AST_LE_IS_LT_OR_EQ: assert property (@(posedge clk) disable iff (rst)
        rel_le == (rel_lt | rel_eq)); // R6
    AST_GE_IS_GT_OR_EQ: assert property (@(posedge clk) disable iff (rst)
        rel_ge == (rel_gt | rel_eq)); // R6
    AST_LOW_SLOTS_ONLY: assert property (@(posedge clk) disable iff (rst || !armed)
        (rel_eq | rel_ne) == low_use); // R7
    AST_ALL_LANES_EQUAL: assert property (@(posedge clk) disable iff (rst || !armed)
        all4_eq_use |-> (rel_eq == '1)); // R3

    generate
        if (OUT_REG) begin : g_reg_chk
            AST_RESET_CLEARS: assert property (@(posedge clk)
                rst |=> (rel_eq == '0 && rel_ne == '0 && rel_lt == '0 &&
                         rel_le == '0 && rel_gt == '0 && rel_ge == '0)); // R8
        end
    endgenerate
endmodule

bind simd_lane_cmp simd_lane_cmp_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .OUT_REG   (OUT_REG)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .part_cut (part_cut),
    .rel_eq   (rel_eq),
    .rel_ne   (rel_ne),
    .rel_lt   (rel_lt),
    .rel_le   (rel_le),
    .rel_gt   (rel_gt),
    .rel_ge   (rel_ge),
    .opa      (opa),
    .opb      (opb)
);

// File: tb/simd_lane_cmp_test.sv
module simd_lane_cmp_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  part_cut = 3'b000;
    logic [15:0] opa = '0, opb = '0;
    logic [3:0]  r_eq, r_ne, r_lt, r_le, r_gt, r_ge;
    logic [3:0]  c_eq, c_ne, c_lt, c_le, c_gt, c_ge;

    int n_checks = 0;
    int n_fail   = 0;

    logic [23:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    simd_lane_cmp #(.OUT_REG(1'b1)) uut (
        .clk(clk), .rst(rst), .part_cut(part_cut), .opa(opa), .opb(opb),
        .rel_eq(r_eq), .rel_ne(r_ne), .rel_lt(r_lt),
        .rel_le(r_le), .rel_gt(r_gt), .rel_ge(r_ge)
    );

    simd_lane_cmp #(.OUT_REG(1'b0)) uut_comb (
        .clk(clk), .rst(rst), .part_cut(part_cut), .opa(opa), .opb(opb),
        .rel_eq(c_eq), .rel_ne(c_ne), .rel_lt(c_lt),
        .rel_le(c_le), .rel_gt(c_gt), .rel_ge(c_ge)
    );

    // Lane model: packed as {eq, ne, lt, le, gt, ge}, 4 bits each.
    function automatic logic [23:0] model(logic [2:0] cut, logic [15:0] a, logic [15:0] b);
        logic [3:0] e = '0, n = '0, l = '0, le = '0, g = '0, ge = '0;
        int w = (cut == 3'b000) ? 16 : (cut == 3'b010) ? 8 : 4;
        for (int lo = 0; lo < 16; lo += w) begin
            int unsigned m  = (32'd1 << w) - 1;
            int unsigned av = (32'(a) >> lo) & m;
            int unsigned bv = (32'(b) >> lo) & m;
            int s = lo / 4;
            e[s]  = (av == bv);
            n[s]  = (av != bv);
            l[s]  = (av <  bv);
            le[s] = (av <= bv);
            g[s]  = (av >  bv);
            ge[s] = (av >= bv);
        end
        return {e, n, l, le, g, ge};
    endfunction

    task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply one vector, check the combinational copy, queue for the registered one.
    task automatic drive(logic [2:0] cut, logic [15:0] a, logic [15:0] b, string tag);
        @(negedge clk);
        part_cut = cut;
        opa      = a;
        opb      = b;
        exp_q.push_back(model(cut, a, b));
        tag_q.push_back(tag);
        #1;
        check({tag, " R9 comb"}, {c_eq, c_ne, c_lt, c_le, c_gt, c_ge}, model(cut, a, b));
    endtask

    // Monitor: registered outputs carry last cycle's inputs.
    always @(posedge clk) begin
        #1;
        if (!rst && exp_q.size() > 0) begin
            logic [23:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " R8 reg"}, {r_eq, r_ne, r_lt, r_le, r_gt, r_ge}, e);
        end
    end

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset state", {r_eq, r_ne, r_lt, r_le, r_gt, r_ge}, 24'h0);
        @(negedge clk);
        rst = 1'b0;

        // R1 single 16-bit lane, R4 unsigned
        drive(3'b000, 16'h0000, 16'h0000, "R1 zero equal");
        drive(3'b000, 16'h1234, 16'h1235, "R1 less");
        drive(3'b000, 16'hFFFF, 16'h0000, "R1 greater R7");
        drive(3'b000, 16'h8000, 16'h7FFF, "R4 top bit 16");
        // R2 two 8-bit lanes
        drive(3'b010, 16'h12AB, 16'h12AC, "R2 low less");
        drive(3'b010, 16'h0100, 16'h00FF, "R2 mixed");
        drive(3'b010, 16'h80FF, 16'h7F00, "R4 top bit 8");
        // R3 four 4-bit lanes
        drive(3'b111, 16'h1234, 16'h4321, "R3 mixed");
        drive(3'b111, 16'hF0F0, 16'h0F0F, "R3 R4 alternating");
        drive(3'b111, 16'hAAAA, 16'hAAAA, "R3 all equal");
        // R5 isolation: differences outside a lane
        drive(3'b010, 16'hFF05, 16'h0005, "R5 low lane equal");
        drive(3'b111, 16'h0F00, 16'h0E00, "R5 one slot differs");
        drive(3'b000, 16'h0001, 16'h0000, "R5 R6 lsb only");
        // pseudo-random sweep over the three splits
        lf = 16'hACE1;
        for (int k = 0; k < 30; k++) begin
            logic [15:0] ra, rb;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            ra = lf;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            rb = (k % 4 == 0) ? ra : lf;
            drive((k % 3 == 0) ? 3'b000 : (k % 3 == 1) ? 3'b010 : 3'b111,
                  ra, rb, "R6 R7 sweep");
        end
        wait (exp_q.size() == 0);

        // R8 reset mid-run clears the registered outputs
        @(negedge clk);
        part_cut = 3'b111;
        opa = 16'h1234;
        opb = 16'h1234;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R8 reset clears", {r_eq, r_ne, r_lt, r_le, r_gt, r_ge}, 24'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule